// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects thirty-two asynchronous interrupt pins and turns each into a latched pending bit. Every pin has its own trigger condition: one of two levels, one of two edges, or both edges. Pins are organised in banks of eight. Each bank has a control word, a mask byte and a pending byte, all reached through one synchronous register strobe. Each bank also drives one request output. That output is high whenever the bank holds a pending bit whose mask bit is clear.

Pending bits latch whether or not the line is masked. A level-type line keeps setting its pending bit for as long as the pin stays active. Software therefore services the source, clears the pending bit by writing a one to it, and only then unmasks the line. Each pin passes through a two-flop synchroniser. Edges are found by comparing the newest synchronised sample with the one taken a cycle earlier.

The register port is a plain strobe: a write happens on any clock edge where `reg_wr` is high, and read data follows `reg_addr` combinationally. This is control traffic, so it has no valid/ready handshake and cannot apply back-pressure.

Top module: `extint_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, all control words read 0, all mask bytes read 0xFF, all pending bytes read 0 and `irq_req` is 0.
- R2: `reg_addr[1:0]` selects the register: 0 = control, 1 = mask, 2 = pending, 3 = active status. `reg_addr[3:2]` selects the bank. Bit j of a bank-k mask, pending or status byte belongs to pin 8k+j. Byte registers read back zero-extended in `reg_rdata[7:0]`.
- R3: In a control word, bits [4j+2:4j] hold the trigger code of line j: 000 level low, 001 level high, 010 falling edge, 011 rising edge, 100 both edges. Bit 4j+3 is stored and reads back, but it has no effect on triggering.
- R4: A level-type line sets its pending bit on every cycle in which its synchronised input is at the active level, including right after the bit has been cleared.
- R5: An edge-type line sets pending only on its selected transition between two consecutive synchronised samples. A pin change made between clock edges sets pending on the third following rising clock edge and not earlier.
- R6: Trigger codes 101, 110 and 111 never set pending.
- R7: Writing the pending register clears every bit written as 1. Bits written as 0 are unchanged.
- R8: If a trigger and a clearing write hit the same bit on the same edge, the bit stays pending.
- R9: A line whose mask bit is 1 still latches its pending bit, and it does not raise its bank's request.
- R10: `irq_req[k]` and the status register of bank k both show the OR / bitwise value of pending AND NOT mask for that bank. They change in the same cycle as a mask or pending change.
- R11: Writes to the status register change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pins | input | 32 | Asynchronous interrupt pins, pin 8k+j is line j of bank k |
| reg_wr | input | 1 | Write strobe, acts on the rising clock edge |
| reg_addr | input | 4 | Bank in [3:2], register select in [1:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_req | output | 4 | One request per bank |

## Verification
The bench builds the block with its default parameters: four banks of eight lines and a two-stage synchroniser. With these values every bank decode is reachable, including the highest bank, and so are nibble positions up to line 7. The vector loop steps pins spread across all four banks through each of the eight trigger codes, starting from both pin levels. It checks both the latched result and the quiet request of a masked line. Directed tests then cover the exact three-edge latency from pin to pending, the set-over-clear collision, writes of zero to the pending register, stray writes to the status register, and the control bit that is stored but ignored.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic [2:0] {
    TRIG_LVL_LO = 3'b000,
    TRIG_LVL_HI = 3'b001,
    TRIG_FALL   = 3'b010,
    TRIG_RISE   = 3'b011,
    TRIG_BOTH   = 3'b100
  } trig_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_PEND = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic [LINES*3-1:0] cfg,
  input  logic [LINES-1:0]   cur,
  input  logic [LINES-1:0]   prev,
  output logic [LINES-1:0]   hit
);
  for (genvar j = 0; j < LINES; j++) begin : g_line
    logic h;
    always_comb begin
      case (cfg[3*j +: 3])
        TRIG_LVL_LO: h = ~cur[j];
        TRIG_LVL_HI: h = cur[j];
        TRIG_FALL:   h = prev[j] & ~cur[j];
        TRIG_RISE:   h = ~prev[j] & cur[j];
        TRIG_BOTH:   h = prev[j] ^ cur[j];
        default:     h = 1'b0;
      endcase
    end
    assign hit[j] = h;
  end
endmodule

// File: rtl/extint_bank.sv
module extint_bank #(
  parameter int LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic               wr_mask,
  input  logic               wr_pend,
  input  logic [LINES*4-1:0] wdata,
  input  logic [LINES-1:0]   cur,
  input  logic [LINES-1:0]   prev,
  output logic [LINES*4-1:0] cfg_q,
  output logic [LINES-1:0]   mask_q,
  output logic [LINES-1:0]   pend_q,
  output logic [LINES-1:0]   active,
  output logic [LINES-1:0]   hit,
  output logic               req
);
  logic [LINES*3-1:0] type_vec;
  logic [LINES-1:0]   clr;

  for (genvar j = 0; j < LINES; j++) begin : g_type
    assign type_vec[3*j +: 3] = cfg_q[4*j +: 3];
  end

  extint_detect #(.LINES(LINES)) u_detect (
    .cfg  (type_vec),
    .cur  (cur),
    .prev (prev),
    .hit  (hit)
  );

  assign clr = wr_pend ? wdata[LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (wr_ctrl) cfg_q  <= wdata;
      if (wr_mask) mask_q <= wdata[LINES-1:0];
      pend_q <= (pend_q & ~clr) | hit;
    end
  end

  assign active = pend_q & ~mask_q;
  assign req    = |active;
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int  NUM_BANKS      = 4,
  parameter int  LINES_PER_BANK = 8,
  parameter int  SYNC_STAGES    = 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = BANK_W + 2,
  localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK,
  localparam int DATA_W    = LINES_PER_BANK * 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_pins,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_BANKS-1:0] irq_req
);
  localparam int L = LINES_PER_BANK;

  logic [NUM_LINES-1:0] sync_cur, sync_prev_q;
  logic [NUM_LINES-1:0] pend_flat, mask_flat, trig_flat;
  logic [BANK_W-1:0]    bank_sel;
  logic [1:0]           reg_sel;

  logic [DATA_W-1:0] cfg_arr  [NUM_BANKS];
  logic [L-1:0]      mask_arr [NUM_BANKS];
  logic [L-1:0]      pend_arr [NUM_BANKS];
  logic [L-1:0]      act_arr  [NUM_BANKS];

  assign bank_sel = reg_addr[ADDR_W-1:2];
  assign reg_sel  = reg_addr[1:0];

  extint_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_pins),
    .q     (sync_cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sync_prev_q <= '0;
    else        sync_prev_q <= sync_cur;
  end

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic hit_sel;
    assign hit_sel = reg_wr && (bank_sel == BANK_W'(k));

    extint_bank #(.LINES(L)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (hit_sel && reg_sel == SEL_CTRL),
      .wr_mask (hit_sel && reg_sel == SEL_MASK),
      .wr_pend (hit_sel && reg_sel == SEL_PEND),
      .wdata   (reg_wdata),
      .cur     (sync_cur[k*L +: L]),
      .prev    (sync_prev_q[k*L +: L]),
      .cfg_q   (cfg_arr[k]),
      .mask_q  (mask_arr[k]),
      .pend_q  (pend_arr[k]),
      .active  (act_arr[k]),
      .hit     (trig_flat[k*L +: L]),
      .req     (irq_req[k])
    );

    assign pend_flat[k*L +: L] = pend_arr[k];
    assign mask_flat[k*L +: L] = mask_arr[k];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: reg_rdata          = cfg_arr[bank_sel];
      SEL_MASK: reg_rdata[L-1:0]   = mask_arr[bank_sel];
      SEL_PEND: reg_rdata[L-1:0]   = pend_arr[bank_sel];
      default:  reg_rdata[L-1:0]   = act_arr[bank_sel];
    endcase
  end
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
  parameter int  NUM_BANKS      = 4,
  parameter int  LINES_PER_BANK = 8,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = BANK_W + 2,
  localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      reg_wr,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [LINES_PER_BANK-1:0] wdata_lo,
  input logic [NUM_LINES-1:0]      pend_flat,
  input logic [NUM_LINES-1:0]      mask_flat,
  input logic [NUM_LINES-1:0]      trig_flat,
  input logic [NUM_BANKS-1:0]      irq_req
);
  localparam int L = LINES_PER_BANK;

  logic [NUM_LINES-1:0] clr_flat;
  always_comb begin
    clr_flat = '0;
    if (reg_wr && reg_addr[1:0] == 2'd2)
      clr_flat[reg_addr[ADDR_W-1:2]*L +: L] = wdata_lo;
  end

  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    !rst_n |=> (pend_flat == '0 && mask_flat == '1)); // R1

  AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_flat & ~$past(pend_flat) & ~$past(trig_flat)) == '0)); // R5

  AST_TRIG_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_flat & $past(trig_flat)) == $past(trig_flat))); // R8

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_flat & $past(clr_flat & ~trig_flat)) == '0)); // R7

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_chk
    AST_MASKED_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_flat[k*L +: L]) |-> !irq_req[k]); // R9

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && reg_wr && reg_addr == {BANK_W'(k), 2'd1})
        |-> (mask_flat[k*L +: L] == $past(wdata_lo))); // R2
  end
endmodule

bind extint_ctrl extint_ctrl_chk #(
  .NUM_BANKS      (NUM_BANKS),
  .LINES_PER_BANK (LINES_PER_BANK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .wdata_lo  (reg_wdata[LINES_PER_BANK-1:0]),
  .pend_flat (pend_flat),
  .mask_flat (mask_flat),
  .trig_flat (trig_flat),
  .irq_req   (irq_req)
);

// File: tb/test_extint_ctrl.sv
module test_extint_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] ctrl_sh [4];

  always #10 clk = ~clk;

  extint_ctrl i_extint_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pins(pins), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req)
  );

  // {code[2:0], start level, end level, expected pending}
  localparam logic [5:0] VEC [16] = '{
    {3'd0, 1'b1, 1'b1, 1'b0}, {3'd0, 1'b1, 1'b0, 1'b1}, {3'd0, 1'b0, 1'b1, 1'b1},
    {3'd1, 1'b0, 1'b0, 1'b0}, {3'd1, 1'b0, 1'b1, 1'b1},
    {3'd2, 1'b1, 1'b0, 1'b1}, {3'd2, 1'b0, 1'b1, 1'b0}, {3'd2, 1'b1, 1'b1, 1'b0},
    {3'd3, 1'b0, 1'b1, 1'b1}, {3'd3, 1'b1, 1'b0, 1'b0},
    {3'd4, 1'b0, 1'b1, 1'b1}, {3'd4, 1'b1, 1'b0, 1'b1}, {3'd4, 1'b1, 1'b1, 1'b0},
    {3'd5, 1'b0, 1'b1, 1'b0}, {3'd6, 1'b1, 1'b0, 1'b0}, {3'd7, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] bank, input logic [1:0] sel,
                           input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {bank, sel}; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] bank, input logic [1:0] sel,
                          output logic [31:0] data);
    reg_addr = {bank, sel};
    #1 data = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic set_nibble(input int line, input logic [3:0] nib);
    ctrl_sh[line/8][4*(line%8) +: 4] = nib;
    reg_write(2'(line/8), 2'd0, ctrl_sh[line/8]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: defaults while reset is held
    reg_read(2'd3, 2'd0, rd); check(rd == 32'h0, "R1 ctrl bank3", rd, 32'h0);
    reg_read(2'd2, 2'd1, rd); check(rd == 32'hFF, "R1 mask bank2", rd, 32'hFF);
    reg_read(2'd1, 2'd2, rd); check(rd == 32'h0, "R1 pend bank1", rd, 32'h0);
    check(irq_req == 4'h0, "R1 irq", 32'(irq_req), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    reg_read(2'd0, 2'd1, rd); check(rd == 32'hFF, "R1 mask after release", rd, 32'hFF);

    for (int b = 0; b < 4; b++) begin
      ctrl_sh[b] = 32'h33333333;
      reg_write(2'(b), 2'd0, ctrl_sh[b]);
    end
    settle();
    for (int b = 0; b < 4; b++) reg_write(2'(b), 2'd2, 32'hFF);
    reg_read(2'd0, 2'd2, rd); check(rd == 32'h0, "R7 clear all", rd, 32'h0);

    // vector table: masked lines across all banks
    for (int i = 0; i < 16; i++) begin
      int n;
      logic [2:0] code;
      logic st, en, ex;
      string tag;
      n = (i * 7) % 32;
      {code, st, en, ex} = VEC[i];
      tag = (code >= 3'd5) ? "R6" : (code <= 3'd1) ? "R4" : "R5";
      pins[n] = st;
      settle();
      set_nibble(n, {1'b0, code});
      settle();
      reg_write(2'(n/8), 2'd2, 32'(1) << (n % 8));
      pins[n] = en;
      settle();
      reg_read(2'(n/8), 2'd2, rd);
      check(rd[n%8] == ex, $sformatf("%s/R2 vec %0d line %0d", tag, i, n),
            32'(rd[n%8]), 32'(ex));
      check(irq_req == 4'h0, $sformatf("R9 vec %0d masked irq", i),
            32'(irq_req), 32'h0);
      set_nibble(n, 4'h3);
      pins[n] = 1'b0;
      settle();
      reg_write(2'(n/8), 2'd2, 32'hFF);
    end

    // R10: unmasked line in bank 3
    reg_write(2'd3, 2'd1, 32'hDF);
    pins[29] = 1'b1;
    settle();
    check(irq_req == 4'b1000, "R10 irq bank3", 32'(irq_req), 32'h8);
    reg_read(2'd3, 2'd3, rd); check(rd == 32'h20, "R10 status bank3", rd, 32'h20);
    reg_read(2'd3, 2'd2, rd); check(rd == 32'h20, "R2 pend bank3", rd, 32'h20);
    // R11: status write ignored
    reg_write(2'd3, 2'd3, 32'h0);
    reg_read(2'd3, 2'd3, rd); check(rd == 32'h20, "R11 status write", rd, 32'h20);
    reg_read(2'd3, 2'd1, rd); check(rd == 32'hDF, "R11 mask kept", rd, 32'hDF);
    // R7: zero write has no effect, one write clears
    reg_write(2'd3, 2'd2, 32'hDF);
    reg_read(2'd3, 2'd2, rd); check(rd == 32'h20, "R7 zero bit kept", rd, 32'h20);
    reg_write(2'd3, 2'd2, 32'h20);
    reg_read(2'd3, 2'd2, rd); check(rd == 32'h0, "R7 one clears", rd, 32'h0);
    check(irq_req == 4'h0, "R10 irq drops", 32'(irq_req), 32'h0);
    // R9 then R10: latch while masked, request on unmask
    reg_write(2'd3, 2'd1, 32'hFF);
    pins[29] = 1'b0; settle();
    pins[29] = 1'b1; settle();
    reg_read(2'd3, 2'd2, rd); check(rd == 32'h20, "R9 latched masked", rd, 32'h20);
    check(irq_req == 4'h0, "R9 no irq masked", 32'(irq_req), 32'h0);
    reg_write(2'd3, 2'd1, 32'hDF);
    check(irq_req == 4'b1000, "R10 irq on unmask", 32'(irq_req), 32'h8);
    reg_write(2'd3, 2'd1, 32'hFF);
    reg_write(2'd3, 2'd2, 32'hFF);
    pins[29] = 1'b0;

    // R8: set wins over clear on a level-high line
    set_nibble(2, 4'h1);
    pins[2] = 1'b1;
    settle();
    reg_write(2'd0, 2'd2, 32'h04);
    reg_read(2'd0, 2'd2, rd); check(rd == 32'h04, "R8 set beats clear", rd, 32'h04);
    pins[2] = 1'b0;
    settle();
    reg_write(2'd0, 2'd2, 32'h04);
    reg_read(2'd0, 2'd2, rd); check(rd == 32'h0, "R4 inactive level stays clear", rd, 32'h0);
    set_nibble(2, 4'h3);

    // R3: top nibble bit stored, ignored for triggering
    set_nibble(9, 4'hB);
    reg_read(2'd1, 2'd0, rd);
    check(rd == 32'h333333B3, "R3 ctrl readback", rd, 32'h333333B3);
    pins[9] = 1'b1;
    settle();
    reg_read(2'd1, 2'd2, rd); check(rd == 32'h02, "R3 top bit ignored", rd, 32'h02);
    pins[9] = 1'b0;
    settle();
    reg_write(2'd1, 2'd2, 32'hFF);

    // R5: exact latency through the synchroniser
    @(negedge clk); pins[16] = 1'b1;
    @(negedge clk); @(negedge clk);
    reg_read(2'd2, 2'd2, rd); check(rd == 32'h0, "R5 not before third edge", rd, 32'h0);
    @(negedge clk);
    reg_read(2'd2, 2'd2, rd); check(rd == 32'h01, "R5 on third edge", rd, 32'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule